// File: doc/BRIEF.md
# Warp Issue Scheduler with Two Alternating Pipes

This block picks at most one resident warp per scheduler cycle and sends that warp's next instruction to one of two execution pipes. Pipe 0 takes multiply-add work. Pipe 1 takes special-function and plain multiply work. Each warp presents three inputs: a residency valid bit, a one-cycle operands-ready set pulse, and the pipe type of its next instruction. The block keeps one ready flag per warp. It sets the flag when the pulse arrives and clears it when the warp issues.

Each pipe is modelled as an occupancy timer. An issued instruction holds its pipe for `OCC` scheduler cycles, which defaults to two. A quarter-wide lane array works through the 32 threads over four fast clocks, which is where the two-cycle hold comes from. Two instructions for the same pipe therefore cannot leave in adjacent cycles. Instructions that alternate between the pipes overlap, and the scheduler can then sustain one issue per cycle.

Among the warps that are valid, ready and aimed at a free pipe, the lowest index wins. The decision is registered, so the issue outputs appear one clock after the state that produced them. The default pool size is 24 resident warps.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, issue_valid is 0 and issue_warp is 0. Reset clears all ready flags and both pipe timers.
- R2: A warp is issued only if, at the deciding clock edge, its warp_valid bit is 1 and its ready flag is set. A ready warp whose warp_valid is 0 keeps its flag and issues once warp_valid becomes 1.
- R3: issue_pipe equals the warp_pipe bit (0 = multiply-add pipe, 1 = special-function/multiply pipe) that the issued warp presented at the deciding edge.
- R4: Among eligible warps whose target pipe is free, the lowest index is issued. A lower-index warp waiting on a busy pipe does not block a higher-index warp bound for the free pipe.
- R5: With OCC = 2, two issues in consecutive cycles never use the same pipe. The pipe is free again two cycles after an issue to it.
- R6: When ready warps alternate pipe types, one issue occurs in every cycle with no gap.
- R7: When no warp is valid, ready and aimed at a free pipe, issue_valid is 0 in the following cycle.
- R8: Issue clears the issued warp's ready flag. The warp is not issued again until a new ready_set pulse arrives.
- R9: If a warp's ready_set pulse is high at the same edge where that warp issues, its ready flag stays set. The warp is issued again once its pipe is free.
- R10: The issue outputs are registered. A ready_set pulse at edge k makes the warp eligible at edge k+1, and its issue appears on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NUM_WARPS | Warp slot holds a resident warp |
| warp_pipe | input | NUM_WARPS | Pipe type of each warp's next instruction (0 multiply-add, 1 special/multiply) |
| ready_set | input | NUM_WARPS | One-cycle pulse: operands of the next instruction are ready |
| issue_valid | output | 1 | An instruction was issued this cycle |
| issue_warp | output | IW | Index of the issued warp |
| issue_pipe | output | 1 | Pipe the issued instruction went to |

## Verification
Two functions can fall on the same clock edge: a warp's ready flag being cleared because it issues, and a fresh ready_set pulse for that same warp. The bench holds the pulse high across the edge where the warp is chosen. It then expects the warp to issue a second time, two cycles later, once its pipe timer expires, and to issue nothing in between. A second coincidence is a warp waiting on a busy pipe in the same cycle that another pipe frees up. The bench judges this by the order of issued warp indices pushed into its scoreboard.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
   typedef enum logic {
      PIPE_MAD = 1'b0,
      PIPE_SFU = 1'b1
   } pipe_e;

   localparam int PIPE_COUNT = 2;
endpackage

// File: rtl/warp_prio_pick.sv
module warp_prio_pick #(
   parameter int N  = 24,
   parameter int IW = 5
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   // lowest set bit isolated arithmetically
   assign onehot = req & (~req + N'(1));

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pipe_occ_timer.sv
module pipe_occ_timer #(
   parameter int OCC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic free
);
   localparam int CW = $clog2(OCC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CW'(OCC - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign free = (cnt_q == '0);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import warp_issue_pkg::*;
#(
   parameter int NUM_WARPS = 24,
   parameter int OCC       = 2,
   parameter int IW        = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] warp_valid,
   input  logic [NUM_WARPS-1:0] warp_pipe,
   input  logic [NUM_WARPS-1:0] ready_set,
   output logic                 issue_valid,
   output logic [IW-1:0]        issue_warp,
   output logic                 issue_pipe
);
   // elaboration-time configuration checks
   if (NUM_WARPS < 1 || NUM_WARPS > 64) begin : g_bad_warps
      $error("warp_issue_sched: NUM_WARPS must be 1..64");
   end
   if (OCC < 2) begin : g_bad_occ
      $error("warp_issue_sched: OCC must be at least 2");
   end
   if ((1 << IW) < NUM_WARPS) begin : g_bad_iw
      $error("warp_issue_sched: IW too narrow for NUM_WARPS");
   end

   logic [NUM_WARPS-1:0]  ready_q;
   logic [NUM_WARPS-1:0]  elig;
   logic [NUM_WARPS-1:0]  pick_oh;
   logic                  pick_any;
   logic [IW-1:0]         pick_idx;
   logic [PIPE_COUNT-1:0] pipe_free;
   logic [PIPE_COUNT-1:0] pipe_start;
   pipe_e                 pick_pipe;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
      assign elig[w] = warp_valid[w] & ready_q[w] & pipe_free[warp_pipe[w]];
   end

   warp_prio_pick #(
      .N  (NUM_WARPS),
      .IW (IW)
   ) u_pick (
      .req    (elig),
      .any    (pick_any),
      .idx    (pick_idx),
      .onehot (pick_oh)
   );

   assign pick_pipe = pipe_e'(warp_pipe[pick_idx]);

   for (genvar p = 0; p < PIPE_COUNT; p++) begin : g_pipe
      assign pipe_start[p] = pick_any && (pick_pipe == pipe_e'(p));

      pipe_occ_timer #(
         .OCC (OCC)
      ) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .start (pipe_start[p]),
         .free  (pipe_free[p])
      );
   end

   // a fresh pulse wins over the clear of the issuing warp
   always_ff @(posedge clk) begin
      if (!rst_n)
         ready_q <= '0;
      else
         ready_q <= (ready_q & ~pick_oh) | ready_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_valid <= 1'b0;
         issue_warp  <= '0;
         issue_pipe  <= 1'b0;
      end else begin
         issue_valid <= pick_any;
         issue_warp  <= pick_any ? pick_idx : '0;
         issue_pipe  <= pick_any ? pick_pipe : 1'b0;
      end
   end
endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk #(
   parameter int NUM_WARPS = 24,
   parameter int IW        = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_WARPS-1:0] warp_valid,
   input logic [NUM_WARPS-1:0] warp_pipe,
   input logic [NUM_WARPS-1:0] rdy_q,
   input logic                 issue_valid,
   input logic [IW-1:0]        issue_warp,
   input logic                 issue_pipe
);
   logic [NUM_WARPS-1:0] valid_d, pipe_d, rdy_d;

   always_ff @(posedge clk) begin
      valid_d <= warp_valid;
      pipe_d  <= warp_pipe;
      rdy_d   <= rdy_q;
   end

   // R2
   warp_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (valid_d[issue_warp] && rdy_d[issue_warp]));

   // R2
   warp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (int'(issue_warp) < NUM_WARPS));

   // R3
   pipe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_pipe == pipe_d[issue_warp]));

   // R5
   same_pipe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && $past(issue_valid)) |-> (issue_pipe != $past(issue_pipe)));

   // R7
   idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((valid_d & rdy_d) == '0) |-> !issue_valid);
endmodule

bind warp_issue_sched issue_sched_chk #(
   .NUM_WARPS (NUM_WARPS),
   .IW        (IW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .warp_valid  (warp_valid),
   .warp_pipe   (warp_pipe),
   .rdy_q       (ready_q),
   .issue_valid (issue_valid),
   .issue_warp  (issue_warp),
   .issue_pipe  (issue_pipe)
);

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 24;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] warp_valid = '0;
   logic [NW-1:0] warp_pipe = '0;
   logic [NW-1:0] ready_set = '0;
   logic          issue_valid;
   logic [IW-1:0] issue_warp;
   logic          issue_pipe;

   int       checks = 0;
   int       errors = 0;
   bit       done = 1'b0;
   logic [IW:0] expq[$];
   logic [IW:0] mon_item;

   always #(CLK_PERIOD/2) clk = ~clk;

   warp_issue_sched #(.NUM_WARPS(NW), .OCC(2), .IW(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_pipe(warp_pipe),
      .ready_set(ready_set), .issue_valid(issue_valid), .issue_warp(issue_warp),
      .issue_pipe(issue_pipe)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver side: push expected issue (pipe, warp)
   task automatic expect_issue(int w, bit p);
      expq.push_back({p, IW'(w)});
   endtask

   // monitor: pops one expected item per observed issue
   always @(negedge clk) begin
      if (rst_n && !done && issue_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R2/R8", "unexpected issue of warp", int'(issue_warp), -1);
         end else begin
            mon_item = expq.pop_front();
            chk(issue_warp == mon_item[IW-1:0], "R4", "issued warp",
                int'(issue_warp), int'(mon_item[IW-1:0]));
            chk(issue_pipe == mon_item[IW], "R3", "issued pipe",
                int'(issue_pipe), int'(mon_item[IW]));
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
      chk(issue_warp == '0, "R1", "issue_warp after reset", int'(issue_warp), 0);

      warp_valid = '1;
      warp_pipe = '0;
      warp_pipe[4] = 1'b1;
      warp_pipe[6] = 1'b1;
      warp_pipe[9] = 1'b1;
      warp_pipe[20] = 1'b1;
      repeat (3) @(negedge clk);
      #1 chk(issue_valid == 1'b0, "R7", "no ready warp", int'(issue_valid), 0);

      // R6 R10: alternating pipes 3(M) 4(S) 5(M) 6(S) in consecutive cycles
      @(negedge clk);
      expect_issue(3, 0); expect_issue(4, 1); expect_issue(5, 0); expect_issue(6, 1);
      ready_set = (NW'(1) << 3) | (NW'(1) << 4) | (NW'(1) << 5) | (NW'(1) << 6);
      @(negedge clk);
      ready_set = '0;
      #1 chk(expq.size() == 4, "R10", "no issue one edge after pulse", expq.size(), 4);
      repeat (4) @(negedge clk);
      #1 chk(expq.size() == 0, "R6", "four issues in four cycles", expq.size(), 0);
      repeat (3) @(negedge clk);

      // R5: three multiply-add warps 0,1,2 -> gaps between issues
      expect_issue(0, 0); expect_issue(1, 0); expect_issue(2, 0);
      ready_set = NW'(7);
      @(negedge clk);
      ready_set = '0;
      @(negedge clk);
      @(negedge clk);
      #1 chk(issue_valid == 1'b0, "R5", "same pipe blocked next cycle", int'(issue_valid), 0);
      @(negedge clk);
      #1 chk(expq.size() == 1, "R5", "second issue after two cycles", expq.size(), 1);
      @(negedge clk);
      @(negedge clk);
      #1 chk(expq.size() == 0, "R5", "third issue after four cycles", expq.size(), 0);

      // R8: issued warps stay quiet without a new pulse
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #1 chk(issue_valid == 1'b0, "R8", "no reissue without pulse", int'(issue_valid), 0);
      end

      // R2: ready but not valid warp 0 waits, warp 7 goes
      warp_valid[0] = 1'b0;
      expect_issue(7, 0);
      ready_set = (NW'(1) << 0) | (NW'(1) << 7);
      @(negedge clk);
      ready_set = '0;
      repeat (4) @(negedge clk);
      #1 chk(expq.size() == 0, "R2", "only valid warp issued", expq.size(), 0);
      chk(issue_valid == 1'b0, "R2", "invalid ready warp held", int'(issue_valid), 0);
      expect_issue(0, 0);
      warp_valid[0] = 1'b1;
      @(negedge clk);
      #1 chk(expq.size() == 0, "R2", "held warp issues when valid", expq.size(), 0);
      repeat (3) @(negedge clk);

      // R9: pulse coincides with issue of warp 9 (special pipe)
      expect_issue(9, 1); expect_issue(9, 1);
      ready_set = NW'(1) << 9;
      @(negedge clk);
      @(negedge clk);
      ready_set = '0;
      @(negedge clk);
      #1 chk(issue_valid == 1'b0, "R9", "pipe still busy", int'(issue_valid), 0);
      @(negedge clk);
      #1 chk(expq.size() == 0, "R9", "warp reissued after collision", expq.size(), 0);
      repeat (4) @(negedge clk);
      #1 chk(issue_valid == 1'b0, "R8", "no third issue", int'(issue_valid), 0);

      // R4: 12(M) 13(M) 20(S): 13 waits behind busy pipe, 20 overtakes
      expect_issue(12, 0); expect_issue(20, 1); expect_issue(13, 0);
      ready_set = (NW'(1) << 12) | (NW'(1) << 13) | (NW'(1) << 20);
      @(negedge clk);
      ready_set = '0;
      repeat (4) @(negedge clk);
      #1 chk(expq.size() == 0, "R4", "free pipe bypass order done", expq.size(), 0);
      repeat (3) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule